// File: doc/BRIEF.md
# Multi-Size Integer Arithmetic Unit

This unit does the integer add and subtract work of a small CPU datapath that handles 8-, 16- and 32-bit data. It covers several operation families:

- plain add and subtract;
- add and subtract with the carry or borrow folded in;
- increment and decrement by a small step;
- a 32-bit address-style add or subtract of 1, 2 or 4;
- decimal correction of a byte result after an addition or a subtraction.

The result is combinational. Bits of the destination value that lie above the selected size pass through unchanged. The condition flags N, Z, V, C and H sit in a register inside the unit. That register is updated on the clock edge at which `issue` is high and the decoded form is legal.

A request is one set of inputs plus the `issue` strobe. The unit takes one request on every cycle where `issue` is high. It never stalls, so it has no ready output and applies no back-pressure. Control inputs and flag outputs are plain level signals. The operation and size codes are decoded without a wider instruction context. A form that breaks an operation's size or step rules is flagged on `illegal` and does nothing.

Top module: `msa_unit`

## Requirements
- R1: Operation codes: 0 add, 1 subtract, 2 add-with-carry, 3 subtract-with-borrow, 4 increment, 5 decrement, 6 address add, 7 address subtract, 8 decimal adjust after add, 9 decimal adjust after subtract. Codes 10 to 15 are illegal. Size codes: 0 byte, 1 word, 2 longword, 3 illegal. Plain add and subtract accept all three sizes and take the second operand from `src`, or from `imm` when `use_imm` is 1. `result` holds the sum or difference in the low bits of the size and `dst` above them.
- R2: Subtract with `use_imm`=1 at byte size is illegal. For any illegal form, `illegal` is 1, `result` equals `dst`, and the flags do not change on that issue.
- R3: Add-with-carry and subtract-with-borrow are legal at byte size only. They add or subtract the held C flag as well as the operand (register or immediate).
- R4: After add-with-carry or subtract-with-borrow, Z is the old Z ANDed with "result is zero", so a cleared Z stays cleared.
- R5: Increment and decrement use `step` as the constant. At byte size only step 1 is legal; at word and longword size steps 1 and 2 are legal. They update N, Z and V and leave C and H unchanged.
- R6: Address add and subtract are legal only at longword size with step 1, 2 or 4. They work on all 32 bits and leave every flag unchanged.
- R7: Decimal adjust after add is byte-only. It adds 0x06 if H is set or the low digit exceeds 9. It adds 0x60 if C is set or the byte exceeds 0x99, and C becomes 1 in that case and keeps its old value otherwise. After a byte add of two BCD values it yields the BCD sum modulo 100, with C set when the sum is 100 or more.
- R8: Decimal adjust after subtract is byte-only. It subtracts 0x06 if H is set and 0x60 if C is set, and keeps C. After a byte subtract of two BCD values it yields the BCD difference modulo 100, with C set on a borrow.
- R9: N is the top bit of the sized result, Z is set for a zero sized result, V is signed overflow at that size, C is the carry or borrow out of the top bit, and H is the carry or borrow out of bit 3, 11 or 27 for byte, word or longword. After a decimal adjust, N and Z follow the adjusted byte while V and H keep their values.
- R10: Reset clears all five flags. Without `issue` the flags hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset of the flag register |
| issue | input | 1 | Request strobe; legal requests update the flags at this edge |
| op | input | 4 | Operation code |
| size | input | 2 | Operand size code |
| use_imm | input | 1 | Selects `imm` instead of `src` as second operand |
| src | input | 32 | Second operand from a register |
| imm | input | 32 | Second operand from the instruction |
| step | input | 3 | Constant for increment, decrement and address forms |
| dst | input | 32 | Destination register value (first operand) |
| result | output | 32 | New destination value |
| illegal | output | 1 | Decoded form is not legal |
| flag_n | output | 1 | Held negative flag |
| flag_z | output | 1 | Held zero flag |
| flag_v | output | 1 | Held overflow flag |
| flag_c | output | 1 | Held carry flag |
| flag_h | output | 1 | Held half-carry flag |

## Verification
`result` and `illegal` are due in the same cycle as the request because they depend only on the inputs and the held flags. The flags are due one clock after the issuing edge. The bench drives each request on a falling edge and checks `result` and `illegal` a few nanoseconds later, before any clock edge. It checks the flags at the next falling edge, after exactly one rising edge has loaded them. Decimal adjustment is checked in two ways: against an arithmetic model of the flags, and against plain decimal sums and differences of BCD operand pairs, which do not depend on the correction rules.

// File: rtl/msa_pkg.sv
package msa_pkg;
  localparam int DW = 32;

  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_SUB  = 4'd1,
    OP_ADC  = 4'd2,
    OP_SBC  = 4'd3,
    OP_INC  = 4'd4,
    OP_DEC  = 4'd5,
    OP_ADA  = 4'd6,
    OP_SBA  = 4'd7,
    OP_DADD = 4'd8,
    OP_DSUB = 4'd9
  } op_e;

  typedef enum logic [1:0] {
    SZ_B = 2'd0,
    SZ_W = 2'd1,
    SZ_L = 2'd2
  } sz_e;

  typedef struct packed {
    logic n;
    logic z;
    logic v;
    logic c;
    logic h;
  } ccr_t;
endpackage

// File: rtl/msa_legal.sv
module msa_legal
  import msa_pkg::*;
(
  input  logic [3:0] op,
  input  logic [1:0] size,
  input  logic       use_imm,
  input  logic [2:0] step,
  output logic       legal
);
  logic size_ok;
  logic step12;
  logic step124;

  always_comb begin
    size_ok = (size != 2'd3);
    step12  = (step == 3'd1) || (step == 3'd2);
    step124 = step12 || (step == 3'd4);
    legal   = 1'b0;
    case (op)
      OP_ADD:                       legal = size_ok;
      OP_SUB:                       legal = size_ok && !(use_imm && size == SZ_B);
      OP_ADC, OP_SBC,
      OP_DADD, OP_DSUB:             legal = (size == SZ_B);
      OP_INC, OP_DEC:               legal = (size == SZ_B) ? (step == 3'd1) : (size_ok && step12);
      OP_ADA, OP_SBA:               legal = (size == SZ_L) && step124;
      default:                      legal = 1'b0;
    endcase
  end
endmodule

// File: rtl/msa_adder.sv
module msa_adder
  import msa_pkg::*;
#(
  parameter int DATA_W = DW
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic              sub,
  input  logic              cin,
  input  logic [1:0]        size,
  output logic [DATA_W-1:0] sum,
  output ccr_t              flags
);
  localparam int NL = $clog2(DATA_W / 8) + 1;

  logic [DATA_W-1:0] lane_sum [NL];
  ccr_t              lane_f   [NL];

  for (genvar k = 0; k < NL; k++) begin : g_lane
    localparam int LW  = 8 << k;
    localparam int LOW = LW - 4;

    logic [LW:0]  full;
    logic [LOW:0] part;
    logic [LW:0]  ci_w;
    logic [LOW:0] ci_p;
    ccr_t         lf;

    assign ci_w = {{LW{1'b0}}, cin};
    assign ci_p = {{LOW{1'b0}}, cin};

    always_comb begin
      if (sub) begin
        full = {1'b0, a[LW-1:0]}  - {1'b0, b[LW-1:0]}  - ci_w;
        part = {1'b0, a[LOW-1:0]} - {1'b0, b[LOW-1:0]} - ci_p;
      end else begin
        full = {1'b0, a[LW-1:0]}  + {1'b0, b[LW-1:0]}  + ci_w;
        part = {1'b0, a[LOW-1:0]} + {1'b0, b[LOW-1:0]} + ci_p;
      end
      lf.n = full[LW-1];
      lf.z = (full[LW-1:0] == '0);
      lf.c = full[LW];
      lf.h = part[LOW];
      if (sub) lf.v = (a[LW-1] != b[LW-1]) && (full[LW-1] != a[LW-1]);
      else     lf.v = (a[LW-1] == b[LW-1]) && (full[LW-1] != a[LW-1]);
    end

    assign lane_f[k] = lf;

    if (LW < DATA_W) begin : g_keep
      assign lane_sum[k] = {a[DATA_W-1:LW], full[LW-1:0]};
    end else begin : g_full
      assign lane_sum[k] = full[LW-1:0];
    end
  end

  always_comb begin
    sum   = lane_sum[0];
    flags = lane_f[0];
    for (int i = 1; i < NL; i++) begin
      if (int'(size) == i) begin
        sum   = lane_sum[i];
        flags = lane_f[i];
      end
    end
  end
endmodule

// File: rtl/msa_bcd_adj.sv
module msa_bcd_adj (
  input  logic [7:0] x,
  input  logic       c_in,
  input  logic       h_in,
  input  logic       sub,
  output logic [7:0] y,
  output logic       c_out
);
  logic fix_lo;
  logic fix_hi;

  always_comb begin
    if (sub) begin
      fix_lo = h_in;
      fix_hi = c_in;
      y      = x - {fix_hi ? 4'h6 : 4'h0, fix_lo ? 4'h6 : 4'h0};
      c_out  = c_in;
    end else begin
      fix_lo = h_in || (x[3:0] > 4'd9);
      fix_hi = c_in || (x > 8'h99);
      y      = x + {fix_hi ? 4'h6 : 4'h0, fix_lo ? 4'h6 : 4'h0};
      c_out  = fix_hi;
    end
  end
endmodule

// File: rtl/msa_ccr.sv
module msa_ccr
  import msa_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  ccr_t d,
  output ccr_t q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (load) q <= d;
  end
endmodule

// File: rtl/msa_unit.sv
module msa_unit
  import msa_pkg::*;
#(
  parameter int DATA_W = DW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue,
  input  logic [3:0]        op,
  input  logic [1:0]        size,
  input  logic              use_imm,
  input  logic [DATA_W-1:0] src,
  input  logic [DATA_W-1:0] imm,
  input  logic [2:0]        step,
  input  logic [DATA_W-1:0] dst,
  output logic [DATA_W-1:0] result,
  output logic              illegal,
  output logic              flag_n,
  output logic              flag_z,
  output logic              flag_v,
  output logic              flag_c,
  output logic              flag_h
);
  logic              legal;
  logic              is_sub;
  logic              cin;
  logic [1:0]        lane_sel;
  logic [DATA_W-1:0] opnd;
  logic [DATA_W-1:0] add_res;
  logic [DATA_W-1:0] res;
  logic [7:0]        bcd_y;
  logic              bcd_c;
  ccr_t              add_f;
  ccr_t              nxt;
  ccr_t              ccr_q;

  msa_legal u_legal (
    .op      (op),
    .size    (size),
    .use_imm (use_imm),
    .step    (step),
    .legal   (legal)
  );

  assign illegal = !legal;

  always_comb begin
    is_sub   = (op == OP_SUB) || (op == OP_SBC) || (op == OP_DEC) || (op == OP_SBA);
    cin      = ((op == OP_ADC) || (op == OP_SBC)) ? ccr_q.c : 1'b0;
    lane_sel = ((op == OP_ADA) || (op == OP_SBA)) ? SZ_L : size;
    case (op)
      OP_INC, OP_DEC, OP_ADA, OP_SBA: opnd = DATA_W'(step);
      default:                        opnd = use_imm ? imm : src;
    endcase
  end

  msa_adder #(.DATA_W(DATA_W)) u_add (
    .a     (dst),
    .b     (opnd),
    .sub   (is_sub),
    .cin   (cin),
    .size  (lane_sel),
    .sum   (add_res),
    .flags (add_f)
  );

  msa_bcd_adj u_bcd (
    .x     (dst[7:0]),
    .c_in  (ccr_q.c),
    .h_in  (ccr_q.h),
    .sub   (op == OP_DSUB),
    .y     (bcd_y),
    .c_out (bcd_c)
  );

  always_comb begin
    res = add_res;
    nxt = ccr_q;
    if (!legal) begin
      res = dst;
    end else begin
      case (op)
        OP_ADD, OP_SUB: nxt = add_f;
        OP_ADC, OP_SBC: begin
          nxt   = add_f;
          nxt.z = ccr_q.z & add_f.z;
        end
        OP_INC, OP_DEC: begin
          nxt.n = add_f.n;
          nxt.z = add_f.z;
          nxt.v = add_f.v;
        end
        OP_DADD, OP_DSUB: begin
          res   = {dst[DATA_W-1:8], bcd_y};
          nxt.n = bcd_y[7];
          nxt.z = (bcd_y == 8'h00);
          nxt.c = bcd_c;
        end
        default: ;
      endcase
    end
  end

  assign result = res;

  msa_ccr u_ccr (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (issue && legal),
    .d     (nxt),
    .q     (ccr_q)
  );

  assign flag_n = ccr_q.n;
  assign flag_z = ccr_q.z;
  assign flag_v = ccr_q.v;
  assign flag_c = ccr_q.c;
  assign flag_h = ccr_q.h;

  AST_SUBIMM_BYTE_ILLEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    issue && op == OP_SUB && use_imm && size == SZ_B |-> illegal); // R2

  AST_ILLEGAL_FREEZES_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    issue && illegal |=> $stable(ccr_q)); // R2

  AST_CHAIN_Z_STAYS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    issue && !illegal && (op == OP_ADC || op == OP_SBC) && !flag_z |=> !flag_z); // R4

  AST_STEP_KEEPS_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
    issue && !illegal && (op == OP_INC || op == OP_DEC) |=> $stable(flag_c) && $stable(flag_h)); // R5

  AST_ADDR_FLAGS_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    issue && (op == OP_ADA || op == OP_SBA) |=> $stable(ccr_q)); // R6

  AST_DADJ_CARRY_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    issue && !illegal && op == OP_DADD && flag_c |=> flag_c); // R7

  AST_DSUB_CARRY_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    issue && !illegal && op == OP_DSUB |=> $stable(flag_c)); // R8

  AST_IDLE_HOLDS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    !issue |=> $stable(ccr_q)); // R10
endmodule

// File: tb/msa_unit_test.sv
module msa_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        t_issue = 1'b0;
  logic [3:0]  t_op = 4'd0;
  logic [1:0]  t_size = 2'd0;
  logic        t_imm_sel = 1'b0;
  logic [31:0] t_src = '0;
  logic [31:0] t_imm = '0;
  logic [2:0]  t_step = 3'd0;
  logic [31:0] t_dst = '0;
  logic [31:0] result;
  logic        illegal;
  logic        flag_n, flag_z, flag_v, flag_c, flag_h;

  int n_chk = 0;
  int n_fail = 0;
  bit mn = 0, mz = 0, mv = 0, mc = 0, mh = 0;
  logic [31:0] last_out;

  always #10 clk = ~clk;

  msa_unit uut (
    .clk(clk), .rst_n(rst_n), .issue(t_issue), .op(t_op), .size(t_size),
    .use_imm(t_imm_sel), .src(t_src), .imm(t_imm), .step(t_step), .dst(t_dst),
    .result(result), .illegal(illegal), .flag_n(flag_n), .flag_z(flag_z),
    .flag_v(flag_v), .flag_c(flag_c), .flag_h(flag_h)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] to_bcd(input int v);
    return {4'(v / 10), 4'(v % 10)};
  endfunction

  task automatic model(input logic [3:0] o, input logic [1:0] s, input bit ui,
                       input logic [31:0] d, input logic [31:0] sr, input logic [31:0] im,
                       input logic [2:0] st, output logic [31:0] er, output bit eill);
    bit ok, sub, nc, fhi, flo;
    int w;
    longint mask, hm, half, av, bv, ci, r, sa, sb, sres;
    logic [7:0] x, y;
    case (o)
      4'd0:                    ok = (s < 3);
      4'd1:                    ok = (s < 3) && !(ui && s == 0);
      4'd2, 4'd3, 4'd8, 4'd9:  ok = (s == 0);
      4'd4, 4'd5:              ok = (s == 0 && st == 1) || ((s == 1 || s == 2) && (st == 1 || st == 2));
      4'd6, 4'd7:              ok = (s == 2) && (st == 1 || st == 2 || st == 4);
      default:                 ok = 0;
    endcase
    eill = !ok;
    er = d;
    if (!ok) return;
    if (o == 8 || o == 9) begin
      x = d[7:0];
      if (o == 8) begin
        fhi = mc || (x > 8'h99);
        flo = mh || (x[3:0] > 4'd9);
        y = x + (fhi ? 8'h60 : 8'h00) + (flo ? 8'h06 : 8'h00);
        nc = fhi;
      end else begin
        y = x - (mc ? 8'h60 : 8'h00) - (mh ? 8'h06 : 8'h00);
        nc = mc;
      end
      er = {d[31:8], y};
      mn = y[7]; mz = (y == 0); mc = nc;
      return;
    end
    w    = (o == 6 || o == 7) ? 32 : (8 << s);
    sub  = (o == 1 || o == 3 || o == 5 || o == 7);
    ci   = (o == 2 || o == 3) ? longint'(mc) : 0;
    mask = (64'd1 << w) - 1;
    hm   = (64'd1 << (w - 4)) - 1;
    half = 64'd1 << (w - 1);
    av   = {32'd0, d} & mask;
    bv   = (o >= 4) ? longint'(st) : ({32'd0, (ui ? im : sr)} & mask);
    if (sub) begin
      r  = (av - bv - ci) & mask;
      nc = (av < bv + ci);
      flo = ((av & hm) < (bv & hm) + ci);
    end else begin
      r  = (av + bv + ci) & mask;
      nc = (av + bv + ci) > mask;
      flo = ((av & hm) + (bv & hm) + ci) > hm;
    end
    sa   = (av >= half) ? av - 2 * half : av;
    sb   = (bv >= half) ? bv - 2 * half : bv;
    sres = sub ? sa - sb - ci : sa + sb + ci;
    er   = (d & ~mask[31:0]) | r[31:0];
    case (o)
      4'd0, 4'd1: begin
        mn = r[w-1]; mz = (r == 0); mv = (sres < -half) || (sres >= half); mc = nc; mh = flo;
      end
      4'd2, 4'd3: begin
        mn = r[w-1]; mz = mz && (r == 0); mv = (sres < -half) || (sres >= half); mc = nc; mh = flo;
      end
      4'd4, 4'd5: begin
        mn = r[w-1]; mz = (r == 0); mv = (sres < -half) || (sres >= half);
      end
      default: ;
    endcase
  endtask

  task automatic run(input logic [3:0] o, input logic [1:0] s, input bit ui,
                     input logic [31:0] d, input logic [31:0] sr, input logic [31:0] im,
                     input logic [2:0] st, input string tag);
    logic [31:0] er;
    bit eill;
    t_op = o; t_size = s; t_imm_sel = ui; t_dst = d; t_src = sr; t_imm = im; t_step = st;
    t_issue = 1'b1;
    #2;
    model(o, s, ui, d, sr, im, st, er, eill);
    last_out = result;
    chk(tag, result, er);
    chk(tag, {31'd0, illegal}, {31'd0, eill});
    @(negedge clk);
    t_issue = 1'b0;
    chk(tag, {27'd0, flag_n, flag_z, flag_v, flag_c, flag_h}, {27'd0, mn, mz, mv, mc, mh});
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R10 reset", {27'd0, flag_n, flag_z, flag_v, flag_c, flag_h}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R9 directed boundaries
    run(4'd0, 2'd1, 0, 32'hAAAA_0FFF, 32'h1, 0, 0, "R9 word half carry");
    chk("R9 H", {31'd0, flag_h}, 32'd1);
    run(4'd0, 2'd2, 0, 32'h7FFF_FFFF, 32'h1, 0, 0, "R9 long overflow");
    chk("R9 V", {31'd0, flag_v}, 32'd1);
    run(4'd1, 2'd2, 1, 32'h0, 0, 32'h1, 0, "R9 long borrow");
    chk("R9 C", {31'd0, flag_c}, 32'd1);

    // R10 idle hold: inputs change without issue
    t_op = 4'd0; t_size = 2'd0; t_dst = 32'h0; t_src = 32'h0;
    @(negedge clk);
    chk("R10 idle", {27'd0, flag_n, flag_z, flag_v, flag_c, flag_h}, {27'd0, mn, mz, mv, mc, mh});

    // R4 chained zero
    run(4'd0, 2'd0, 0, 32'h0, 32'h0, 0, 0, "R1 zero");
    run(4'd2, 2'd0, 0, 32'h0, 32'h0, 0, 0, "R4 chain zero");
    chk("R4 Z kept", {31'd0, flag_z}, 32'd1);
    run(4'd2, 2'd0, 1, 32'h5, 0, 32'h0, 0, "R4 chain nonzero");
    run(4'd2, 2'd0, 0, 32'h0, 32'h0, 0, 0, "R4 chain zero after");
    chk("R4 Z stays clear", {31'd0, flag_z}, 32'd0);

    // R2 illegal byte immediate subtract
    run(4'd1, 2'd0, 1, 32'h1234_5678, 0, 32'h11, 0, "R2 sub imm byte");
    chk("R2 flag", {31'd0, last_out == 32'h1234_5678}, 32'd1);

    // R1 R2 R3 R5 R6 legality sweep over all codes
    for (int o = 0; o < 16; o++)
      for (int s = 0; s < 4; s++)
        for (int ui = 0; ui < 2; ui++)
          for (int st = 0; st < 8; st++)
            for (int k = 0; k < 2; k++)
              run(4'(o), 2'(s), bit'(ui), $urandom, $urandom, $urandom, 3'(st), "R2 R5 R6 legality");

    // R1 R3 byte sweep with carry chaining
    for (int o = 0; o < 4; o++)
      for (int a = 0; a < 256; a++)
        for (int b = 0; b < 256; b += 9)
          run(4'(o), 2'd0, bit'(b & 1) & (o != 1), {24'hC3A5E1, 8'(a)}, 32'(b) | 32'hFF00, 32'(b), 0,
              (o < 2) ? "R1 byte" : "R3 byte carry");

    // R5 R6 word and longword
    for (int k = 0; k < 3000; k++)
      run(4'($urandom_range(0, 7)), 2'($urandom_range(1, 2)), bit'($urandom_range(0, 1)),
          $urandom, $urandom, $urandom, 3'($urandom_range(1, 4)), "R1 R5 R6 wide");
    run(4'd6, 2'd2, 0, 32'hFFFF_FFFE, 0, 0, 3'd4, "R6 wrap");
    chk("R6 wrap value", last_out, 32'h0000_0002);
    run(4'd4, 2'd0, 0, 32'h0000_00FF, 0, 0, 3'd1, "R5 byte wrap");
    chk("R5 upper kept", last_out, 32'h0000_0000);

    // R7 decimal add and R8 decimal subtract
    for (int a = 0; a < 100; a++)
      for (int b = 0; b < 100; b++) begin
        run(4'd0, 2'd0, 1, {24'h5A5A5A, to_bcd(a)}, 0, {24'd0, to_bcd(b)}, 0, "R1 bcd add");
        run(4'd8, 2'd0, 0, last_out, 0, 0, 0, "R7 adjust");
        chk("R7 decimal sum", {24'd0, last_out[7:0]}, {24'd0, to_bcd((a + b) % 100)});
        chk("R7 decimal carry", {31'd0, flag_c}, {31'd0, (a + b) >= 100});
        run(4'd1, 2'd0, 0, {24'h5A5A5A, to_bcd(a)}, {24'd0, to_bcd(b)}, 0, 0, "R1 bcd sub");
        run(4'd9, 2'd0, 0, last_out, 0, 0, 0, "R8 adjust");
        chk("R8 decimal diff", {24'd0, last_out[7:0]}, {24'd0, to_bcd((a - b + 100) % 100)});
        chk("R8 decimal borrow", {31'd0, flag_c}, {31'd0, a < b});
      end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule